// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog built on a 64-bit up-counter that is split into two 32-bit words, with a matching 64-bit period held in two more words. Software reaches it through a simple 32-bit register port. Software first sets the period and the counting controls. It then arms the watchdog by writing two 16-bit keys in a fixed order into the watchdog control word. Once the first key has been accepted, the counting and period configuration is frozen.

While armed, software must service the watchdog with the same key pair before the count climbs to the period. If the count reaches the period, or a key other than the expected one arrives while armed, the block does four things:
- it drives a one-cycle reset pulse,
- it latches a timeout flag,
- it stops the counter,
- it falls back to the disabled state.

The flag stays set until software writes a one to it or the system reset is applied.

Top module: `keyed_watchdog`

## Requirements
- R1: After the synchronous reset `rst`, every register reads zero, the block is in the disabled state (enable bit 14 of the watchdog control word reads 0) and `wd_rst_o` is low.
- R2: Word addresses 4 to 10 (byte offsets 0x10 to 0x28) select count low, count high, period low, period high, timer control (mode field in bits 7:6), global control (bits 3:0) and watchdog control. A read strobe returns the selected word on `rdata` one clock later.
- R3: The counter increments by one per clock only when all of the following hold: the timer mode field is nonzero, global bits 1:0 are both 1, global bits 3:2 equal 2, and the timeout flag is clear. A carry from the low word propagates into the high word, and count reads return the live value.
- R4: A write of key 0xA5C6 in bits 31:16 with bit 14 set moves disabled to pre-active, and bit 14 then reads 1. In the disabled state the same key with bit 14 clear is ignored. Key 0xDA7E with bit 14 set then moves pre-active to active and clears the count to zero.
- R5: In the pre-active, active and service states, writes to the count, period, timer control and global control words are ignored.
- R6: In the active state, key 0xA5C6 enters the service state. Key 0xDA7E from the service state returns to active and clears the count to zero, with no reset pulse.
- R7: A watchdog control write in the active or service state whose key is not the expected next key triggers the following on the next clock:
  - `wd_rst_o` rises for exactly one cycle.
  - The timeout flag (bit 15) is set.
  - The block returns to the disabled state.
- R8: When the count equals the period in the active or service state, the next clock produces the following:
  - a one-cycle `wd_rst_o` pulse,
  - the timeout flag set,
  - a return to the disabled state,
  - the counter held at the period value.

  With the period at 50 and the count just cleared, the pulse follows the clearing write by 51 clocks.
- R9: Writing 1 to bit 15 of the watchdog control word clears the timeout flag, after which counting resumes if it is configured.
- R10: In the pre-active state a wrong key is ignored: the state is kept and no reset pulse is issued.
- R11: In the disabled state the counter passes the period freely and no reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions rely on two properties of the register port:
- At most one write happens per clock.
- The count only moves through a write, a key restart or an enabled increment.

Because of this, a halted counter and a frozen period can be checked as stable whenever no write strobe is present. The stimulus issues every access as a single-cycle strobe driven on the falling edge, and never overlaps a read with a write. Keys are always sent whole in bits 31:16. Periods are kept small so that a timeout arrives within tens of clocks of the last clearing write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_PRE = 2'd1,
    ST_RUN = 2'd2,
    ST_SVC = 2'd3
  } wd_state_e;

  localparam int IDX_CNT0 = 4;
  localparam int IDX_PRD0 = 6;
  localparam int IDX_TCTL = 8;
  localparam int IDX_GCTL = 9;
  localparam int IDX_WCTL = 10;

  localparam int KEY_W = 16;
  localparam int BIT_EN = 14;
  localparam int BIT_FLAG = 15;
endpackage

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  localparam int NH    = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [NH-1:0]     half_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] wval;

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign wval[h*DATA_W +: DATA_W] = half_wr[h] ? wdata : cnt[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (|half_wr)   cnt <= wval;
    else if (run)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
  import kwd_pkg::*;
#(
  parameter logic [15:0] KEY_ARM = 16'hA5C6,
  parameter logic [15:0] KEY_SVC = 16'hDA7E
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic [15:0] key,
  input  logic        en_bit,
  input  logic        clr_bit,
  input  logic        hit,
  output wd_state_e   state,
  output logic        flag,
  output logic        fire,
  output logic        restart,
  output logic        wd_rst_o
);
  wd_state_e nxt;
  logic      armed;

  assign armed = (state == ST_RUN) || (state == ST_SVC);

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    fire    = 1'b0;
    if (ctl_wr) begin
      case (state)
        ST_OFF: if (key == KEY_ARM && en_bit) nxt = ST_PRE;
        ST_PRE: if (key == KEY_SVC && en_bit) begin
                  nxt     = ST_RUN;
                  restart = 1'b1;
                end
        ST_RUN: if (key == KEY_ARM) nxt = ST_SVC;
                else fire = 1'b1;
        ST_SVC: if (key == KEY_SVC) begin
                  nxt     = ST_RUN;
                  restart = 1'b1;
                end else fire = 1'b1;
        default: nxt = ST_OFF;
      endcase
    end
    if (armed && hit) begin
      fire    = 1'b1;
      restart = 1'b0;
    end
    if (fire) nxt = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      flag     <= 1'b0;
      wd_rst_o <= 1'b0;
    end else begin
      state    <= nxt;
      wd_rst_o <= fire;
      if (fire)                 flag <= 1'b1;
      else if (ctl_wr && clr_bit) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  localparam int NH    = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  input  logic              flag,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  prd,
  output logic              run_cfg,
  output logic [NH-1:0]     cnt_wr,
  output logic              ctl_wr,
  output logic [DATA_W-1:0] rdata
);
  logic [1:0]        tmode;
  logic [3:0]        gctl;
  logic [NH-1:0]     prd_wr;
  logic [CNT_W-1:0]  prd_nxt;
  logic              cfg_wr;
  logic [DATA_W-1:0] rmux;

  assign cfg_wr = wr_en && !locked;
  assign ctl_wr = wr_en && (int'(addr) == IDX_WCTL);

  for (genvar h = 0; h < NH; h++) begin : g_dec
    assign cnt_wr[h] = cfg_wr && (int'(addr) == IDX_CNT0 + h);
    assign prd_wr[h] = cfg_wr && (int'(addr) == IDX_PRD0 + h);
    assign prd_nxt[h*DATA_W +: DATA_W] = prd_wr[h] ? wdata : prd[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd   <= '0;
      tmode <= '0;
      gctl  <= '0;
    end else begin
      prd <= prd_nxt;
      if (cfg_wr && int'(addr) == IDX_TCTL) tmode <= wdata[7:6];
      if (cfg_wr && int'(addr) == IDX_GCTL) gctl  <= wdata[3:0];
    end
  end

  assign run_cfg = (tmode != 2'd0) && (gctl[1:0] == 2'b11) && (gctl[3:2] == 2'd2);

  always_comb begin
    rmux = '0;
    for (int h = 0; h < NH; h++) begin
      if (int'(addr) == IDX_CNT0 + h) rmux = cnt[h*DATA_W +: DATA_W];
      if (int'(addr) == IDX_PRD0 + h) rmux = prd[h*DATA_W +: DATA_W];
    end
    if (int'(addr) == IDX_TCTL) rmux[7:6] = tmode;
    if (int'(addr) == IDX_GCTL) rmux[3:0] = gctl;
    if (int'(addr) == IDX_WCTL) begin
      rmux[BIT_FLAG] = flag;
      rmux[BIT_EN]   = locked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter int          CNT_W   = 64,
  parameter logic [15:0] KEY_ARM = 16'hA5C6,
  parameter logic [15:0] KEY_SVC = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wd_rst_o
);
  localparam int NH = CNT_W / DATA_W;

  wd_state_e        state_q;
  logic             flag_q;
  logic             fire;
  logic             restart;
  logic             run_cfg;
  logic             ctl_wr;
  logic [NH-1:0]    cnt_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] prd_q;
  logic             locked;

  assign locked = (state_q != ST_OFF);

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .locked(locked), .flag(flag_q), .cnt(cnt_q),
    .prd(prd_q), .run_cfg(run_cfg), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
    .rdata(rdata)
  );

  kwd_keyfsm #(.KEY_ARM(KEY_ARM), .KEY_SVC(KEY_SVC)) u_fsm (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
    .key(wdata[DATA_W-1 -: KEY_W]), .en_bit(wdata[BIT_EN]),
    .clr_bit(wdata[BIT_FLAG]), .hit(cnt_q == prd_q),
    .state(state_q), .flag(flag_q), .fire(fire), .restart(restart),
    .wd_rst_o(wd_rst_o)
  );

  kwd_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_cfg && !flag_q && !fire),
    .restart(restart), .half_wr(cnt_wr), .wdata(wdata), .cnt(cnt_q)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wd_rst_o,
  input logic             flag,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd
);
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |=> !wd_rst_o);

  p_pulse_flag_r8: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |-> (flag && state == 2'd0));

  p_pulse_armed_r11: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |-> $past(state[1]));

  p_locked_period_r5: assert property (@(posedge clk) disable iff (rst)
    (state != 2'd0) |=> $stable(prd));

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && $past(state) != 2'd2) |-> (cnt == '0));

  p_halt_on_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (flag && !wr_en) |=> $stable(cnt));
endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wd_rst_o(wd_rst_o),
  .flag(flag_q), .state(state_q), .cnt(cnt_q), .prd(prd_q)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wd_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int pulse_cyc = -1;
  bit done = 0;

  localparam logic [3:0] A_CLO = 4'd4, A_CHI = 4'd5, A_PLO = 4'd6, A_PHI = 4'd7,
                         A_TCT = 4'd8, A_GCT = 4'd9, A_WCT = 4'd10;

  keyed_watchdog u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst_o(wd_rst_o));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (wd_rst_o) begin
    pulses++;
    pulse_cyc = cyc;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rst_o", wd_rst_o, 0);
    for (int a = 4; a <= 10; a++) begin
      rd(4'(a), d);
      chk("R1 reg zero", d, 0);
    end
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(A_GCT, 32'hB);
    wr(A_TCT, 32'h0);
    rd(A_GCT, d); chk("R2 gctl readback", d, 32'hB);
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 32'h0);
    wr(A_TCT, 32'h80);
    wr(A_TCT, 32'h0);
    rd(A_CLO, d); chk("R3 carry low", d, 0);
    rd(A_CHI, d); chk("R3 carry high", d, 1);
    wr(A_GCT, 32'h7);
    wr(A_TCT, 32'h80);
    rd(A_TCT, d); chk("R2 tctl readback", d, 32'h80);
    repeat (5) @(negedge clk);
    rd(A_CLO, d); chk("R3 no count in wrong mode", d, 0);
  endtask

  task automatic t_arm;
    logic [31:0] d;
    int c0, p0;
    wr(A_PLO, 32'd50);
    wr(A_PHI, 32'd0);
    wr(A_GCT, 32'hB);
    wr(A_WCT, 32'hA5C6_0000);
    rd(A_WCT, d); chk("R4 key without enable ignored", d[14], 0);
    wr(A_WCT, 32'hA5C6_4000);
    rd(A_WCT, d); chk("R4 pre-active enable bit", d[14], 1);
    p0 = pulses;
    wr(A_WCT, 32'h1234_4000);
    rd(A_WCT, d); chk("R10 wrong key kept pre-active", d[14], 1);
    chk("R10 no pulse", pulses, p0);
    wr(A_PLO, 32'd5);
    wr(A_GCT, 32'h0);
    rd(A_PLO, d); chk("R5 period locked", d, 50);
    rd(A_GCT, d); chk("R5 gctl locked", d, 32'hB);
    wr(A_WCT, 32'hDA7E_4000);
    rd(A_CLO, d); chk("R4 count cleared on active", d, 0);
    repeat (10) @(negedge clk);
    wr(A_WCT, 32'hA5C6_0000);
    wr(A_WCT, 32'hDA7E_0000);
    c0 = cyc;
    rd(A_CLO, d); chk("R6 service clears count", d, 0);
    chk("R6 no pulse on service", pulses, p0);
    repeat (60) @(negedge clk);
    chk("R8 one pulse", pulses, p0 + 1);
    chk("R8 timeout delay", pulse_cyc - c0, 51);
    rd(A_WCT, d);
    chk("R8 flag set", d[15], 1);
    chk("R8 back to disabled", d[14], 0);
    rd(A_CLO, d); chk("R8 count held at period", d, 50);
    wr(A_WCT, 32'h0000_8000);
    repeat (100) @(negedge clk);
    rd(A_CLO, d); chk("R11 free count past period", d, 150);
    rd(A_WCT, d); chk("R9 flag cleared", d[15], 0);
    chk("R11 no pulse when disabled", pulses, p0 + 1);
  endtask

  task automatic t_badkey;
    logic [31:0] d;
    int c1, p0;
    wr(A_PLO, 32'd1000);
    wr(A_WCT, 32'hA5C6_4000);
    wr(A_WCT, 32'hDA7E_4000);
    p0 = pulses;
    wr(A_WCT, 32'h0000_4000);
    c1 = cyc;
    repeat (3) @(negedge clk);
    chk("R7 pulse from active", pulses, p0 + 1);
    chk("R7 pulse timing", pulse_cyc, c1);
    rd(A_WCT, d);
    chk("R7 flag set", d[15], 1);
    chk("R7 disabled", d[14], 0);
    wr(A_WCT, 32'h0000_8000);
    wr(A_WCT, 32'hA5C6_4000);
    wr(A_WCT, 32'hDA7E_4000);
    wr(A_WCT, 32'hA5C6_0000);
    wr(A_WCT, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R7 pulse from service", pulses, p0 + 2);
  endtask

  task automatic t_reset_armed;
    logic [31:0] d;
    wr(A_WCT, 32'h0000_8000);
    wr(A_WCT, 32'hA5C6_4000);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(A_WCT, d); chk("R1 reset from armed", d, 0);
    rd(A_PLO, d); chk("R1 period cleared", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_arm();
    t_badkey();
    t_reset_armed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule